// File: doc/BRIEF.md
# Multi-Word Big-Integer Shifter

This unit shifts a big integer, held as a vector of 64-bit words, left or right by 0 to 63 bit positions. Word 0 is the least significant. The operation runs one word per clock. A double-width element processes each word. It merges the carry bits from the neighbouring word into the shifted word, and it hands the bits that leave the word to the next word as its carry.

A caller presents the whole vector, the number of words in use, a shift-amount operand, a direction and a carry-in word, then pulses `start`. The unit captures these operands and walks the active words. A right shift goes from the most significant word down to word 0. A left shift goes from word 0 upward. At the end the unit raises `done` for one cycle. It then presents the shifted vector and the final carry-out word. For a right shift the carry-out holds the bits shifted out below word 0. For a left shift it holds the bits pushed out above the top active word. Because a carry-in word is accepted, shifts can be chained across several invocations.

Top module: `bigint_shifter`

## Requirements
- R1: Only bits [5:0] of `shift_amt` set the shift distance n (0..63). All higher bits have no effect.
- R2: Right shift (`shift_right`=1): each active word becomes its source shifted right by n. Bits [63:64-n] of that word come from the incoming carry. For the top active word, that carry is `carry_in`, and only its bits [63:64-n] are used.
- R3: Right shift order is word `vec_len`-1 down to word 0. The carry passed downward is the n low bits of the source word, placed at bits [63:64-n] with zeros below them. After word 0 this carry is returned on `carry_out`.
- R4: Left shift (`shift_right`=0): each active word becomes its source shifted left by n. Bits [n-1:0] of that word come from the incoming carry. For word 0, that carry is `carry_in`, and only its bits [n-1:0] are used.
- R5: Left shift order is word 0 up to word `vec_len`-1. The carry passed upward is the n high bits of the source word, placed at bits [n-1:0] with zeros above them. After the top active word this carry is returned on `carry_out`.
- R6: With n = 0 every active word is returned unchanged, `carry_in` is not used, and `carry_out` is zero.
- R7: Words at indices `vec_len` through MAX_WORDS-1 are returned equal to their input values.
- R8: After a start is accepted on a clock edge, `busy` is high for exactly `vec_len` cycles. `done` is high for one cycle right after that. `busy` and `done` are never high together. The result and carry-out are valid while `done` is high and hold until the next accepted start.
- R9: A `start` pulse while `busy` is high is ignored. The operation in flight completes with its captured operands.
- R10: After reset, `busy`, `done`, `carry_out` and `words_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| shift_right | input | 1 | 1 = right shift, 0 = left shift |
| shift_amt | input | AMT_W | Shift-amount operand; low 6 bits used |
| vec_len | input | $clog2(MAX_WORDS+1) | Number of active words, 1..MAX_WORDS |
| carry_in | input | 64 | Carry word fed into the first word processed |
| words_in | input | 64*MAX_WORDS | Source vector, word i at bits [64i+63:64i] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| words_out | output | 64*MAX_WORDS | Result vector |
| carry_out | output | 64 | Final carry-out / remainder word |

## Verification
The assertions assume that `vec_len` lies between 1 and MAX_WORDS whenever `start` is raised. The index-range and ordering checks depend on this. The stimulus picks every length from that range, including 1 and MAX_WORDS, and never raises `start` with a zero or oversized length. Shift amounts are drawn from the full operand width, so that the upper bits exercise R1 while n still covers 0 and 63. A second `start` is pulsed deliberately while an operation is running, with different operands, so that the assertion guarding the captured length and direction is exercised.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

    localparam int WORD_W  = 64;
    localparam int SHAMT_W = 6;
    localparam int DW_W    = 2 * WORD_W;
    localparam int ROT_W   = SHAMT_W + 1;

    typedef enum logic {
        SHIFT_LEFT  = 1'b0,
        SHIFT_RIGHT = 1'b1
    } shift_dir_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] carry;
    } elem_out_t;

    // Rotate a double-width value left by amt (0..127).
    function automatic logic [DW_W-1:0] rotl_dw(input logic [DW_W-1:0] v,
                                                input logic [ROT_W-1:0] amt);
        logic [ROT_W:0] back;
        back = (ROT_W+1)'(DW_W) - {1'b0, amt};
        return (v << amt) | (v >> back);
    endfunction

    // Bits [63:64-n] set.
    function automatic logic [WORD_W-1:0] hi_mask(input logic [SHAMT_W-1:0] n);
        return ~({WORD_W{1'b1}} >> n);
    endfunction

    // Bits [n-1:0] set.
    function automatic logic [WORD_W-1:0] lo_mask(input logic [SHAMT_W-1:0] n);
        return ~({WORD_W{1'b1}} << n);
    endfunction

endpackage

// File: rtl/bsh_element.sv
module bsh_element
    import bsh_pkg::*;
(
    input  logic [WORD_W-1:0]  src,
    input  logic [WORD_W-1:0]  cin,
    input  logic [SHAMT_W-1:0] n,
    input  shift_dir_e         dir,
    output elem_out_t          res
);

    logic [DW_W-1:0]  rot;
    logic [ROT_W-1:0] amt;

    always_comb begin
        if (dir == SHIFT_RIGHT) begin
            // rotate left by 128-n == rotate right by n
            amt      = ROT_W'(0) - {1'b0, n};
            rot      = rotl_dw({src, {WORD_W{1'b0}}}, amt);
            res.word  = rot[DW_W-1:WORD_W] | (cin & hi_mask(n));
            res.carry = rot[WORD_W-1:0];
        end else begin
            amt      = {1'b0, n};
            rot      = rotl_dw({{WORD_W{1'b0}}, src}, amt);
            res.word  = rot[WORD_W-1:0] | (cin & lo_mask(n));
            res.carry = rot[DW_W-1:WORD_W];
        end
    end

endmodule

// File: rtl/bsh_sequencer.sv
module bsh_sequencer
    import bsh_pkg::*;
#(
    parameter int MAX_WORDS = 4,
    parameter int IDX_W     = 2,
    parameter int LEN_W     = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  shift_dir_e         dir_in,
    input  logic [SHAMT_W-1:0] n_in,
    input  logic [LEN_W-1:0]   len_in,
    output logic               busy,
    output logic               done,
    output logic               load,
    output logic               last,
    output logic [IDX_W-1:0]   idx,
    output shift_dir_e         dir_q,
    output logic [SHAMT_W-1:0] n_q
);

    logic [LEN_W-1:0] len_q;

    assign load = start && !busy;
    assign last = (dir_q == SHIFT_RIGHT) ? (idx == '0)
                                         : (LEN_W'(idx) == len_q - LEN_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            done  <= 1'b0;
            idx   <= '0;
            len_q <= '0;
            dir_q <= SHIFT_LEFT;
            n_q   <= '0;
        end else begin
            done <= 1'b0;
            if (load) begin
                busy  <= 1'b1;
                len_q <= len_in;
                dir_q <= dir_in;
                n_q   <= n_in;
                idx   <= (dir_in == SHIFT_RIGHT) ? IDX_W'(len_in - LEN_W'(1)) : '0;
            end else if (busy) begin
                if (last) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (dir_q == SHIFT_RIGHT) begin
                    idx <= idx - IDX_W'(1);
                end else begin
                    idx <= idx + IDX_W'(1);
                end
            end
        end
    end

    // R8
    busy_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(busy));

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> ($stable(len_q) && $stable(dir_q) && $stable(n_q)));

    // R7
    idx_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (LEN_W'(idx) < len_q));

endmodule

// File: rtl/bsh_wordbank.sv
module bsh_wordbank
    import bsh_pkg::*;
#(
    parameter int MAX_WORDS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [MAX_WORDS*WORD_W-1:0] load_data,
    input  logic                        wr,
    input  logic [IDX_W-1:0]            idx,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [WORD_W-1:0]           rd_data,
    output logic [MAX_WORDS*WORD_W-1:0] flat
);

    logic [WORD_W-1:0] bank [MAX_WORDS];

    for (genvar g = 0; g < MAX_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                bank[g] <= '0;
            end else if (load) begin
                bank[g] <= load_data[g*WORD_W +: WORD_W];
            end else if (wr && (idx == IDX_W'(g))) begin
                bank[g] <= wr_data;
            end
        end
        assign flat[g*WORD_W +: WORD_W] = bank[g];
    end

    assign rd_data = bank[idx];

endmodule

// File: rtl/bigint_shifter.sv
module bigint_shifter
    import bsh_pkg::*;
#(
    parameter int MAX_WORDS = 4,
    parameter int AMT_W     = 64
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              start,
    input  logic                              shift_right,
    input  logic [AMT_W-1:0]                  shift_amt,
    input  logic [$clog2(MAX_WORDS+1)-1:0]    vec_len,
    input  logic [WORD_W-1:0]                 carry_in,
    input  logic [MAX_WORDS*WORD_W-1:0]       words_in,
    output logic                              busy,
    output logic                              done,
    output logic [MAX_WORDS*WORD_W-1:0]       words_out,
    output logic [WORD_W-1:0]                 carry_out
);

    localparam int LEN_W = $clog2(MAX_WORDS + 1);
    localparam int IDX_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

    shift_dir_e         dir_in;
    shift_dir_e         dir_q;
    logic [SHAMT_W-1:0] n_q;
    logic               load;
    logic               last;
    logic [IDX_W-1:0]   idx;
    logic [WORD_W-1:0]  src_word;
    logic [WORD_W-1:0]  carry_q;
    logic [WORD_W-1:0]  carry_out_q;
    elem_out_t          elem;

    assign dir_in = shift_right ? SHIFT_RIGHT : SHIFT_LEFT;

    bsh_sequencer #(
        .MAX_WORDS(MAX_WORDS),
        .IDX_W    (IDX_W),
        .LEN_W    (LEN_W)
    ) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .dir_in(dir_in),
        .n_in  (shift_amt[SHAMT_W-1:0]),
        .len_in(vec_len),
        .busy  (busy),
        .done  (done),
        .load  (load),
        .last  (last),
        .idx   (idx),
        .dir_q (dir_q),
        .n_q   (n_q)
    );

    bsh_wordbank #(
        .MAX_WORDS(MAX_WORDS),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_data(words_in),
        .wr       (busy),
        .idx      (idx),
        .wr_data  (elem.word),
        .rd_data  (src_word),
        .flat     (words_out)
    );

    bsh_element u_elem (
        .src(src_word),
        .cin(carry_q),
        .n  (n_q),
        .dir(dir_q),
        .res(elem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_q     <= '0;
            carry_out_q <= '0;
        end else if (load) begin
            carry_q <= carry_in;
        end else if (busy) begin
            carry_q <= elem.carry;
            if (last) begin
                carry_out_q <= elem.carry;
            end
        end
    end

    assign carry_out = carry_out_q;

    // R6
    zero_shift_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && n_q == '0) |-> (elem.word == src_word && elem.carry == '0));

    // R3
    right_carry_top_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && dir_q == SHIFT_RIGHT) |-> ((elem.carry << n_q) == '0));

    // R5
    left_carry_low_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && dir_q == SHIFT_LEFT) |-> ((elem.carry >> n_q) == '0));

    // R8
    carry_out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load) |=> $stable(carry_out));

endmodule

// File: tb/bigint_shifter_tb.sv
module bigint_shifter_tb;

    localparam int MAXW  = 4;
    localparam int AMT_W = 64;
    localparam int LEN_W = $clog2(MAXW + 1);
    localparam int VW    = MAXW * 64;
    localparam int BW    = VW + 64;

    typedef struct {
        logic [VW-1:0] words;
        logic [63:0]   carry;
        int            len;
        string         req;
    } exp_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic             shift_right = 1'b0;
    logic [AMT_W-1:0] shift_amt = '0;
    logic [LEN_W-1:0] vec_len = LEN_W'(1);
    logic [63:0]      carry_in = '0;
    logic [VW-1:0]    words_in = '0;
    logic             busy;
    logic             done;
    logic [VW-1:0]    words_out;
    logic [63:0]      carry_out;

    int   checks = 0;
    int   errors = 0;
    int   busy_cnt = 0;
    exp_t q[$];

    always #5 clk = ~clk;

    bigint_shifter #(.MAX_WORDS(MAXW), .AMT_W(AMT_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .shift_right(shift_right),
        .shift_amt(shift_amt), .vec_len(vec_len), .carry_in(carry_in),
        .words_in(words_in), .busy(busy), .done(done),
        .words_out(words_out), .carry_out(carry_out)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%016h expected 0x%016h", req, what, act, exp);
        end
    endtask

    // Reference built on wide shifts of the whole integer.
    function automatic exp_t model(input bit right, input logic [AMT_W-1:0] amt,
                                   input int len, input logic [63:0] cin,
                                   input logic [VW-1:0] vin, input string req);
        exp_t          e;
        logic [BW-1:0] x;
        int            n;
        n = int'(amt[5:0]);
        e.words = vin;
        e.len   = len;
        e.req   = req;
        x       = '0;
        if (right) begin
            for (int i = 0; i < len; i++) x[64 + 64*i +: 64] = vin[64*i +: 64];
            x = x >> n;
            for (int i = 0; i < len; i++) e.words[64*i +: 64] = x[64 + 64*i +: 64];
            e.words[64*(len-1) +: 64] = e.words[64*(len-1) +: 64]
                                      | (cin & ~((64'd1 << (64 - n)) - 64'd1));
            e.carry = x[63:0];
        end else begin
            for (int i = 0; i < len; i++) x[64*i +: 64] = vin[64*i +: 64];
            x = x << n;
            x[63:0] = x[63:0] | (cin & ((64'd1 << n) - 64'd1));
            for (int i = 0; i < len; i++) e.words[64*i +: 64] = x[64*i +: 64];
            e.carry = x[64*len +: 64];
        end
        return e;
    endfunction

    task automatic issue(input bit right, input logic [AMT_W-1:0] amt, input int len,
                         input logic [63:0] cin, input logic [VW-1:0] vin, input exp_t e);
        @(negedge clk);
        while (busy) @(negedge clk);
        shift_right = right;
        shift_amt   = amt;
        vec_len     = LEN_W'(len);
        carry_in    = cin;
        words_in    = vin;
        start       = 1'b1;
        q.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run(input bit right, input logic [AMT_W-1:0] amt, input int len,
                       input logic [63:0] cin, input logic [VW-1:0] vin, input string req);
        issue(right, amt, len, cin, vin, model(right, amt, len, cin, vin, req));
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_cnt++;
            if (done) begin
                chk(!busy, "R8", "busy during done", 64'(busy), 64'd0);
                if (q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected done", 64'd1, 64'd0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    for (int i = 0; i < MAXW; i++) begin
                        chk(words_out[64*i +: 64] === e.words[64*i +: 64],
                            (i < e.len) ? e.req : "R7", $sformatf("word %0d", i),
                            words_out[64*i +: 64], e.words[64*i +: 64]);
                    end
                    chk(carry_out === e.carry, e.req, "carry_out", carry_out, e.carry);
                    chk(busy_cnt == e.len, "R8", "busy cycles",
                        64'(busy_cnt), 64'(e.len));
                end
                busy_cnt = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", "run did not finish", 64'd0, 64'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t          e;
        logic [VW-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        chk(busy == 1'b0, "R10", "busy", 64'(busy), 64'd0);
        chk(done == 1'b0, "R10", "done", 64'(done), 64'd0);
        chk(carry_out == '0, "R10", "carry_out", carry_out, 64'd0);
        chk(words_out == '0, "R10", "words_out low", words_out[63:0], 64'd0);

        // R2 R3 right-shift worked example, word 3 is outside the length (R7)
        v = {64'h1234_5678_9ABC_DEF0, 64'h0000_0000_5000_0002,
             64'h8000_8000_8000_8001, 64'hFFFF_FFFF_FFFF_FFFF};
        e.words = {64'h1234_5678_9ABC_DEF0, 64'h9000_0000_0500_0000,
                   64'h2800_0800_0800_0800, 64'h1FFF_FFFF_FFFF_FFFF};
        e.carry = 64'hF000_0000_0000_0000;
        e.len   = 3;
        e.req   = "R2/R3";
        issue(1'b1, 64'd4, 3, 64'h9000_0000_0000_0000, v, e);

        // R4 R5 left-shift worked example; R1 via upper amount bits (0xC4 -> 4)
        v = {64'hAAAA_0000_BBBB_0000, 64'h9000_0000_0001_0002,
             64'h3FFF_FFFF_FFFF_FFFF, 64'h4000_0000_0000_0001};
        e.words = {64'hAAAA_0000_BBBB_0000, 64'h0000_0000_0010_0023,
                   64'hFFFF_FFFF_FFFF_FFF4, 64'h0000_0000_0000_001A};
        e.carry = 64'h9;
        e.len   = 3;
        e.req   = "R1/R4/R5";
        issue(1'b0, 64'hFFFF_0000_0000_00C4, 3, 64'hA, v, e);

        // R6 zero shift both directions, carry-in must not leak
        v = {64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210,
             64'hDEAD_BEEF_0000_FFFF, 64'h8000_0000_0000_0001};
        e.words = v; e.carry = '0; e.len = 4; e.req = "R6";
        issue(1'b1, 64'h40, 4, 64'hFFFF_FFFF_FFFF_FFFF, v, e);
        issue(1'b0, 64'h0, 4, 64'hFFFF_FFFF_FFFF_FFFF, v, e);

        // R2 R4 extreme distance with full length
        run(1'b1, 64'd63, MAXW, 64'hC000_0000_0000_0003, v, "R2");
        run(1'b0, 64'd63, MAXW, 64'hC000_0000_0000_0003, v, "R4");

        // R7 single-word vectors
        run(1'b1, 64'd8, 1, 64'hAB00_0000_0000_00CD, v, "R7/R3");
        run(1'b0, 64'd8, 1, 64'hAB00_0000_0000_00CD, v, "R7/R5");

        // R9 second start while busy carries other operands
        run(1'b1, 64'd12, 4, 64'h5555_0000_0000_5555, v, "R9");
        shift_right = 1'b0;
        shift_amt   = 64'd1;
        vec_len     = LEN_W'(2);
        carry_in    = '0;
        words_in    = '0;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;

        // R3 R5 R1 varied patterns
        for (int k = 0; k < 24; k++) begin
            logic [VW-1:0] rv;
            for (int i = 0; i < MAXW; i++) rv[64*i +: 64] = {$urandom, $urandom};
            run(k[0], {$urandom, $urandom}, 1 + (k % MAXW), {$urandom, $urandom},
                rv, k[0] ? "R1/R3" : "R1/R5");
        end

        @(negedge clk);
        while (busy || done) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(q.size() == 0, "R8", "pending results", 64'(q.size()), 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule